// File: doc/BRIEF.md
# Per-Channel Edge-Triggered Output Clear

This block holds the output code of four 12-bit channels and decides what each one holds when a global clear input fires. Software writes three kinds of per-channel state through indexed write ports: the live data code, a programmable clear code and a clear-enable bit. Each port carries a 2-bit channel index.

The clear input is active high and is treated as an event. It passes through a two-flop synchroniser, and its rising edge then produces a single-cycle pulse. On that pulse, every channel whose enable bit is set loads its own clear code. Channels without the enable keep the code they had.

A cleared channel keeps the clear code after the input drops. It changes only when a new data value is written to it. Holding the clear input high has no effect after the first edge. If a data write and a clear pulse reach the same enabled channel in the same cycle, the clear wins.

Top module: `chan_clear_ctrl`

## Requirements
- R1: On reset (rst_ni low), all output codes, clear codes and clear enables become zero. After reset, a clear edge leaves data already written in place, because no channel is enabled.
- R2: A write on the data port with channel index n (0 to 3) changes only `code_o[n]`, one clock edge after it is sampled.
- R3: When `clr_i` is first sampled high at clock edge k, the enabled channels show their clear code after edge k+2 and not before.
- R4: A channel whose clear-enable bit is 0 keeps its output code through a clear edge.
- R5: A clear loads at most once per rising edge of `clr_i`. While `clr_i` stays high, data writes take effect and persist.
- R6: After `clr_i` returns low, a cleared channel holds its clear code until a data write to that channel replaces it.
- R7: If a data write to an enabled channel and the clear pulse fall in the same cycle, the channel loads its clear code and the write is lost.
- R8: Clear-code and enable writes with channel index n change only that channel's stored setting and leave every output unchanged. The enable takes bit value 1 for enabled and 0 for disabled. A later clear uses the latest programmed clear code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_we_i | input | 1 | Data write strobe |
| data_ch_i | input | 2 | Data write channel index |
| data_i | input | 12 | Data code to write |
| ccode_we_i | input | 1 | Clear-code write strobe |
| ccode_ch_i | input | 2 | Clear-code write channel index |
| ccode_i | input | 12 | Clear code to store |
| cen_we_i | input | 1 | Clear-enable write strobe |
| cen_ch_i | input | 2 | Clear-enable write channel index |
| cen_i | input | 1 | Clear-enable value, 1 means enabled |
| clr_i | input | 1 | Clear request, active high, acts on its rising edge |
| code_o | output | 4x12 | Output code of each channel, index 0 to 3 |

## Verification
On every cycle, the assertions check the following:
- an enabled channel takes its stored clear code on the pulse;
- a disabled channel does not move on the pulse;
- a write lands when no clear overrides it;
- an idle channel stays steady;
- the edge detector never pulses twice in a row.

Only the bench scenarios can show the following:
- the exact three-edge latency from the raw clear input;
- the fact that holding the input high never re-clears;
- that a clear-code write reaches the next clear;
- that same-cycle priority is seen at the ports.

// File: rtl/chan_clear_pkg.sv
package chan_clear_pkg;
  localparam int unsigned DEF_NUM_CH      = 4;
  localparam int unsigned DEF_CODE_W      = 12;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/chan_clear_edge.sv
module chan_clear_edge #(
  parameter int unsigned SYNC_STAGES = chan_clear_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= clr_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= 1'b0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign pulse_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R5
endmodule

// File: rtl/chan_clear_slot.sv
module chan_clear_slot #(
  parameter int unsigned CODE_W = chan_clear_pkg::DEF_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_pulse_i,
  input  logic              data_we_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic              ccode_we_i,
  input  logic [CODE_W-1:0] ccode_i,
  input  logic              cen_we_i,
  input  logic              cen_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] ccode_q;
  logic [CODE_W-1:0] out_q;
  logic              en_q;
  logic              do_clear;

  assign do_clear = clr_pulse_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccode_q <= '0;
      en_q    <= 1'b0;
      out_q   <= '0;
    end else begin
      if (ccode_we_i) ccode_q <= ccode_i;
      if (cen_we_i)   en_q    <= cen_i;
      // clear outranks a same-cycle data write
      if (do_clear)       out_q <= ccode_q;
      else if (data_we_i) out_q <= data_i;
    end
  end

  assign code_o = out_q;

  AST_CLEAR_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pulse_i && en_q) |=> (code_o == $past(ccode_q))); // R3
  AST_PRIO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pulse_i && en_q && data_we_i && (data_i != ccode_q)) |=> (code_o != $past(data_i))); // R7
  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pulse_i && !en_q && !data_we_i) |=> $stable(code_o)); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !(clr_pulse_i && en_q)) |=> (code_o == $past(data_i))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_we_i && !clr_pulse_i) |=> $stable(code_o)); // R6
endmodule

// File: rtl/chan_clear_ctrl.sv
module chan_clear_ctrl #(
  parameter  int unsigned NUM_CH      = chan_clear_pkg::DEF_NUM_CH,
  parameter  int unsigned CODE_W      = chan_clear_pkg::DEF_CODE_W,
  parameter  int unsigned SYNC_STAGES = chan_clear_pkg::DEF_SYNC_STAGES,
  localparam int unsigned CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           data_we_i,
  input  logic [CH_W-1:0]                data_ch_i,
  input  logic [CODE_W-1:0]              data_i,
  input  logic                           ccode_we_i,
  input  logic [CH_W-1:0]                ccode_ch_i,
  input  logic [CODE_W-1:0]              ccode_i,
  input  logic                           cen_we_i,
  input  logic [CH_W-1:0]                cen_ch_i,
  input  logic                           cen_i,
  input  logic                           clr_i,
  output logic [NUM_CH-1:0][CODE_W-1:0]  code_o
);
  logic              clr_pulse;
  logic [NUM_CH-1:0] data_sel, ccode_sel, cen_sel;

  chan_clear_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .pulse_o(clr_pulse)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign data_sel[c]  = data_we_i  && (data_ch_i  == CH_W'(c));
    assign ccode_sel[c] = ccode_we_i && (ccode_ch_i == CH_W'(c));
    assign cen_sel[c]   = cen_we_i   && (cen_ch_i   == CH_W'(c));

    chan_clear_slot #(.CODE_W(CODE_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_pulse_i(clr_pulse),
      .data_we_i  (data_sel[c]),
      .data_i     (data_i),
      .ccode_we_i (ccode_sel[c]),
      .ccode_i    (ccode_i),
      .cen_we_i   (cen_sel[c]),
      .cen_i      (cen_i),
      .code_o     (code_o[c])
    );
  end

  AST_WRITE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(data_sel) && $onehot0(ccode_sel) && $onehot0(cen_sel)); // R8
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (code_o == '0)); // R1
endmodule

// File: tb/chan_clear_ctrl_bench.sv
module chan_clear_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  op;  // 0 data, 1 clear code, 2 enable
    logic [1:0]  ch;
    logic [11:0] val;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{2'd0, 2'd0, 12'h111}, '{2'd0, 2'd1, 12'h222}, '{2'd0, 2'd2, 12'h333},
    '{2'd0, 2'd3, 12'h444}, '{2'd1, 2'd0, 12'hA5A}, '{2'd1, 2'd1, 12'hFFF},
    '{2'd1, 2'd2, 12'h0F0}, '{2'd1, 2'd3, 12'h123}, '{2'd2, 2'd0, 12'h001},
    '{2'd2, 2'd2, 12'h001}, '{2'd0, 2'd3, 12'h7FF}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic data_we = 0, ccode_we = 0, cen_we = 0, cen = 0, clr = 0;
  logic [1:0] data_ch = 0, ccode_ch = 0, cen_ch = 0;
  logic [11:0] data = 0, ccode = 0;
  logic [3:0][11:0] code;

  logic [11:0] exp_out [4];
  logic [11:0] exp_cc  [4];
  logic        exp_en  [4];
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_clear_ctrl u_chan_clear_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .data_we_i(data_we), .data_ch_i(data_ch), .data_i(data),
    .ccode_we_i(ccode_we), .ccode_ch_i(ccode_ch), .ccode_i(ccode),
    .cen_we_i(cen_we), .cen_ch_i(cen_ch), .cen_i(cen),
    .clr_i(clr), .code_o(code)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input int ch, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s ch%0d actual=%h expected=%h", req, ch, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 4; c++) check(req, c, code[c], exp_out[c]);
  endtask

  task automatic apply(input vec_t v);
    case (v.op)
      2'd0: begin data_we = 1; data_ch = v.ch; data = v.val; end
      2'd1: begin ccode_we = 1; ccode_ch = v.ch; ccode = v.val; end
      default: begin cen_we = 1; cen_ch = v.ch; cen = v.val[0]; end
    endcase
    tick();
    data_we = 0; ccode_we = 0; cen_we = 0;
    case (v.op)
      2'd0: exp_out[v.ch] = v.val;
      2'd1: exp_cc[v.ch] = v.val;
      default: exp_en[v.ch] = v.val[0];
    endcase
  endtask

  // raise clr, three edges to outputs, then drop and let the synchroniser settle
  task automatic fire_clear(input string req);
    clr = 1;
    tick(); tick();
    check_all("R3 early");
    tick();
    for (int c = 0; c < 4; c++) if (exp_en[c]) exp_out[c] = exp_cc[c];
    check_all(req);
    clr = 0;
    tick(); tick(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin exp_out[c] = 0; exp_cc[c] = 0; exp_en[c] = 0; end
    tick(); tick();
    check_all("R1 in reset");
    rst_ni = 1;
    tick();
    check_all("R1 after reset");

    // R2 / R8 table walk
    for (int i = 0; i < 11; i++) begin
      apply(VECS[i]);
      check_all(VECS[i].op == 2'd0 ? "R2" : "R8");
    end

    // R3 timing, R4 disabled channels 1 and 3 keep 222 / 7FF
    fire_clear("R3 R4");
    check("R4", 1, code[1], 12'h222);
    check("R4", 3, code[3], 12'h7FF);

    // R5: write during held-high clear persists
    clr = 1;
    tick(); tick(); tick();
    apply('{2'd0, 2'd0, 12'h055});
    tick(); tick(); tick();
    check("R5", 0, code[0], 12'h055);
    clr = 0;
    tick(); tick(); tick();
    check_all("R5 R6");
    check("R6", 2, code[2], 12'h0F0);
    apply('{2'd0, 2'd2, 12'h321});
    check("R6", 2, code[2], 12'h321);

    // R7: data write to enabled ch1 on the pulse cycle
    apply('{2'd2, 2'd1, 12'h001});
    clr = 1;
    tick(); tick();
    data_we = 1; data_ch = 2'd1; data = 12'h999;
    tick();
    data_we = 0;
    for (int c = 0; c < 4; c++) if (exp_en[c]) exp_out[c] = exp_cc[c];
    check("R7", 1, code[1], 12'hFFF);
    check_all("R7");
    clr = 0;
    tick(); tick(); tick();

    // R8: new clear code, no output effect; disabled ch0 ignored then re-enabled
    apply('{2'd1, 2'd0, 12'h600});
    check_all("R8 no output effect");
    apply('{2'd2, 2'd0, 12'h000});
    apply('{2'd0, 2'd1, 12'h010});
    apply('{2'd0, 2'd0, 12'h0AA});
    fire_clear("R8 disabled");
    check("R8", 0, code[0], 12'h0AA);
    apply('{2'd2, 2'd0, 12'h001});
    fire_clear("R8 new code");
    check("R8", 0, code[0], 12'h600);

    // R1: reset mid-run clears enables
    rst_ni = 0;
    tick();
    for (int c = 0; c < 4; c++) begin exp_out[c] = 0; exp_cc[c] = 0; exp_en[c] = 0; end
    check_all("R1 mid reset");
    rst_ni = 1;
    tick();
    apply('{2'd0, 2'd0, 12'h321});
    fire_clear("R1 enables zero");
    check("R1", 0, code[0], 12'h321);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule